// File: doc/BRIEF.md
# Compressed Table Jump Unit

This unit executes the two 16-bit table-jump instructions of a compressed instruction set. It receives one instruction word together with the PC of that word and the current value of the jump-table control register. It decides whether the word is a table jump, and whether it is the plain form or the form that also writes a return address. It checks that the table mode is the only supported one, forms the address of the selected table entry, and fetches that entry with one execute-type read over a valid/ready request and a response channel. The fetched entry, with its lowest bit cleared, becomes the new PC.

The result is reported as a one-cycle pulse. A completion pulse carries the target, a link enable and the link value (the instruction PC plus 2, meant for register x1). A trap pulse carries the cause code, the exception PC and the trap value. A word that is not a table jump gives a one-cycle rejection pulse and nothing else. Address translation, permission checks, the register file and the control register itself sit outside the unit. A fault raised by any of them comes back as the response error flag.

Top module: `tbljump_unit`

## Requirements
- R1: A word is accepted only when bits 15:10 equal 101000 and bits 1:0 equal 10. For any other word, `not_mine` pulses for one cycle, the cycle after `start`. No memory request, completion or trap follows, and `busy` stays low.
- R2: The table index is bits 9:2. An index of 32 to 255 selects the linking form: at completion `link_en` is high and `link_data` equals the instruction PC + 2. An index of 0 to 31 (bits 9:7 zero) selects the plain form, and `link_en` stays low.
- R3: If control register bits 5:0 (the mode field) are non-zero, the unit traps with cause 2 (illegal instruction). The trap value is the instruction word zero-extended, the exception PC is the instruction PC, and no memory request is made.
- R4: The entry address is (control register with bits 5:0 forced to zero) + index × (XLEN/8), modulo 2^XLEN.
- R5: Each accepted word with mode zero issues exactly one memory request. While `mem_req_ready` is low, the request stays asserted with a stable address. After the handshake no new request is raised until the response arrives.
- R6: On an error-free response, `done` pulses for one cycle with `done_target` equal to the response data with bit 0 cleared.
- R7: On a response with `mem_rsp_err` set, the unit traps with cause 1 (instruction access fault). The trap value is the entry address and the exception PC is the instruction PC.
- R8: `start` is ignored while `busy` is high. The operation in progress completes unchanged and no rejection pulse is produced.
- R9: During and right after reset, `busy`, `not_mine`, `mem_req_valid`, `done`, `link_en` and `trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Present an instruction word |
| insn | input | 16 | Instruction word |
| pc | input | XLEN | PC of the instruction word |
| tbl_csr | input | XLEN | Jump-table control register: table base in bits XLEN-1:6, mode in bits 5:0 |
| busy | output | 1 | An accepted instruction is in progress |
| not_mine | output | 1 | Rejection pulse for a word that is not a table jump |
| mem_req_valid | output | 1 | Table-entry fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | XLEN | Entry address |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_data | input | XLEN | Table entry |
| mem_rsp_err | input | 1 | Fetch fault |
| done | output | 1 | Completion pulse |
| done_target | output | XLEN | New PC |
| link_en | output | 1 | Write `link_data` to x1 |
| link_data | output | XLEN | Return address |
| trap | output | 1 | Trap pulse |
| trap_cause | output | 5 | Exception cause code |
| trap_epc | output | XLEN | Exception PC |
| trap_tval | output | XLEN | Trap value |

## Verification
Some properties can be checked on every cycle: that the request holds its address under backpressure, that entry addresses are aligned to the entry size, that only one request is outstanding, that targets are even, that `link_en` appears only with `done`, and that the three result pulses are mutually exclusive and single-cycle. The bench scenarios are the only place where the arithmetic values show up. These are the entry address for every index and for a base near the top of the address space, the cleared target bit, the link value, and the cause and value of each trap. The same holds for the classification of every top/low opcode bit combination and for a `start` arriving mid-operation being ignored.

// File: rtl/tbljump_unit.sv
`timescale 1ns/1ps
module tbljump_unit #(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 5,
  parameter int ILL_CAUSE = 2,
  parameter int IAF_CAUSE = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [15:0]        insn,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    tbl_csr,
  output logic               busy,
  output logic               not_mine,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [XLEN-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [XLEN-1:0]    mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               done,
  output logic [XLEN-1:0]    done_target,
  output logic               link_en,
  output logic [XLEN-1:0]    link_data,
  output logic               trap,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_epc,
  output logic [XLEN-1:0]    trap_tval
);
  localparam int ESZ = $clog2(XLEN/8);
  localparam logic [CAUSE_W-1:0] C_ILL = CAUSE_W'(ILL_CAUSE);
  localparam logic [CAUSE_W-1:0] C_IAF = CAUSE_W'(IAF_CAUSE);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_REQ, S_WAIT, S_DONE, S_TRAP} st_t;
  st_t state;

  logic [15:0]        insn_q;
  logic [XLEN-1:0]    pc_q, csr_q, addr_q, tgt_q, tval_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               nm_q;

  wire hit       = (insn[15:10] == 6'b101000) && (insn[1:0] == 2'b10);
  wire [XLEN-1:0] base      = {csr_q[XLEN-1:6], 6'b000000};
  wire [XLEN-1:0] entry_off = XLEN'(insn_q[9:2]) << ESZ;
  wire [XLEN-1:0] entry_adr = base + entry_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      nm_q    <= 1'b0;
      insn_q  <= '0;
      pc_q    <= '0;
      csr_q   <= '0;
      addr_q  <= '0;
      tgt_q   <= '0;
      tval_q  <= '0;
      cause_q <= '0;
    end else begin
      nm_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (hit) begin
            insn_q <= insn;
            pc_q   <= pc;
            csr_q  <= tbl_csr;
            state  <= S_CHECK;
          end else begin
            nm_q <= 1'b1;
          end
        end
        S_CHECK: begin
          if (csr_q[5:0] != 6'd0) begin
            cause_q <= C_ILL;
            tval_q  <= XLEN'(insn_q);
            state   <= S_TRAP;
          end else begin
            addr_q <= entry_adr;
            state  <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            cause_q <= C_IAF;
            tval_q  <= addr_q;
            state   <= S_TRAP;
          end else begin
            tgt_q <= mem_rsp_data & ~XLEN'(1);
            state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state != S_IDLE);
  assign not_mine      = nm_q;
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr  = addr_q;
  assign done          = (state == S_DONE);
  assign done_target   = tgt_q;
  assign link_en       = (state == S_DONE) && (insn_q[9:7] != 3'd0);
  assign link_data     = pc_q + XLEN'(2);
  assign trap          = (state == S_TRAP);
  assign trap_cause    = cause_q;
  assign trap_epc      = pc_q;
  assign trap_tval     = tval_q;
endmodule

// File: rtl/tbljump_unit_chk.sv
`timescale 1ns/1ps
module tbljump_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            not_mine,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            done,
  input logic [XLEN-1:0] done_target,
  input logic            link_en,
  input logic            trap
);
  localparam int ESZ = $clog2(XLEN/8);

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r5_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[ESZ-1:0] == '0);
  a_r6_target_even: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !done_target[0]);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, trap, not_mine}));
  a_r2_link_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    link_en |-> done);
  a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    not_mine |-> !mem_req_valid && !busy);
  a_r8_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
endmodule

bind tbljump_unit tbljump_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .not_mine(not_mine),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .done_target(done_target),
  .link_en(link_en), .trap(trap)
);

// File: tb/sim_tbljump_unit.sv
`timescale 1ns/1ps
module sim_tbljump_unit;
  localparam int XL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] insn = '0;
  logic [XL-1:0] pc = '0, csr = '0;
  logic busy, not_mine, mem_req_valid, done, link_en, trap;
  logic mem_req_ready = 1'b0;
  logic [XL-1:0] mem_req_addr, done_target, link_data, trap_epc, trap_tval;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [XL-1:0] mem_rsp_data = '0;
  logic [4:0] trap_cause;

  always #2.5 clk = ~clk;

  tbljump_unit #(.XLEN(XL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .pc(pc), .tbl_csr(csr),
    .busy(busy), .not_mine(not_mine), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .done(done), .done_target(done_target), .link_en(link_en), .link_data(link_data),
    .trap(trap), .trap_cause(trap_cause), .trap_epc(trap_epc), .trap_tval(trap_tval)
  );

  int checks = 0, fails = 0;
  int stall_left = 0, lat_set = 1, wait_cnt = 0, req_count = 0;
  bit err_set = 0;
  logic [XL-1:0] cap_addr = '0;

  int kind;
  logic [XL-1:0] r_tgt, r_ldata, r_epc, r_tval;
  logic r_len;
  logic [4:0] r_cause;
  bit saw_nm;

  function automatic logic [XL-1:0] mem_val(input logic [XL-1:0] a);
    return (a * 32'h9E3779B1) ^ 32'h2468ACE1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_err = err_set;
          mem_rsp_data = mem_val(cap_addr);
        end
      end
      if (mem_req_valid) begin
        if (stall_left > 0) begin
          mem_req_ready = 1'b0;
          stall_left--;
        end else begin
          mem_req_ready = 1'b1;
          cap_addr = mem_req_addr;
          req_count++;
          wait_cnt = lat_set;
        end
      end else begin
        mem_req_ready = 1'b0;
      end
    end
  end

  task automatic run(input logic [15:0] w, input logic [XL-1:0] p, input logic [XL-1:0] c,
                     input int st, input int lt, input bit er, input bit intrude);
    stall_left = st; lat_set = lt; err_set = er; req_count = 0;
    kind = 0; saw_nm = 0;
    insn = w; pc = p; csr = c; start = 1'b1;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (intrude && n == 2) begin
        start = 1'b1;
        insn = 16'h0001;
      end
      if (not_mine) saw_nm = 1;
      if (done) begin
        kind = 1; r_tgt = done_target; r_len = link_en; r_ldata = link_data;
      end else if (trap) begin
        kind = 2; r_cause = trap_cause; r_epc = trap_epc; r_tval = trap_tval;
      end else if (not_mine && !intrude) begin
        kind = 3;
      end
      if (kind != 0) break;
    end
    if (kind == 0) chk(0, "run timeout", 0, 1);
    @(negedge clk);
  endtask

  function automatic logic [XL-1:0] exp_addr(input logic [15:0] w, input logic [XL-1:0] c);
    return (c & ~32'h3F) + XL'(w[9:2]) * 4;
  endfunction

  task automatic check_good(input logic [15:0] w, input logic [XL-1:0] p, input logic [XL-1:0] c);
    logic [XL-1:0] a;
    a = exp_addr(w, c);
    chk(kind == 1, "R6 done seen", kind, 1);
    chk(cap_addr == a, "R4 entry address", cap_addr, a);
    chk(req_count == 1, "R5 single request", req_count, 1);
    chk(r_tgt == (mem_val(a) & ~32'h1), "R6 target bit0 cleared", r_tgt, mem_val(a) & ~32'h1);
    chk(r_len == (w[9:2] >= 8'd32), "R2 link enable", r_len, w[9:2] >= 8'd32);
    if (w[9:2] >= 8'd32) chk(r_ldata == p + 2, "R2 link data", r_ldata, p + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !not_mine && !mem_req_valid && !done && !link_en && !trap,
        "R9 outputs in reset", {busy, not_mine, mem_req_valid, done, link_en, trap}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !not_mine && !mem_req_valid && !done && !trap,
        "R9 outputs after reset", {busy, not_mine, mem_req_valid, done, trap}, 0);

    // R2 R4 R5 R6: every index, varying stall and latency
    for (int i = 0; i < 256; i++) begin
      logic [15:0] w;
      logic [XL-1:0] p, c;
      w = {6'b101000, 8'(i), 2'b10};
      p = 32'h0001_0000 + 32'(i) * 6;
      c = 32'h8000_0040 + 32'(i % 4) * 32'h40;
      run(w, p, c, i % 3, 1 + i % 2, 0, 0);
      check_good(w, p, c);
    end

    // R4 wrap at top of address space
    for (int i = 240; i < 256; i++) begin
      logic [15:0] w;
      w = {6'b101000, 8'(i), 2'b10};
      run(w, 32'h4, 32'hFFFF_FFC0, 0, 1, 0, 0);
      check_good(w, 32'h4, 32'hFFFF_FFC0);
    end

    // R3 non-zero mode traps without a fetch
    for (int m = 1; m < 64; m++) begin
      logic [15:0] w;
      logic [XL-1:0] p;
      w = {6'b101000, 8'(m * 3), 2'b10};
      p = 32'h2000_0000 + 32'(m) * 2;
      run(w, p, 32'h1000_0000 | 32'(m), 0, 1, 0, 0);
      chk(kind == 2 && r_cause == 5'd2, "R3 illegal cause", r_cause, 2);
      chk(r_tval == {16'h0, w}, "R3 trap value", r_tval, {16'h0, w});
      chk(r_epc == p, "R3 trap epc", r_epc, p);
      chk(req_count == 0, "R3 no fetch", req_count, 0);
    end

    // R7 fetch fault
    for (int i = 0; i < 256; i += 17) begin
      logic [15:0] w;
      logic [XL-1:0] p, c, a;
      w = {6'b101000, 8'(i), 2'b10};
      p = 32'h3000_0100 + 32'(i) * 2;
      c = 32'h0000_1240;
      a = exp_addr(w, c);
      run(w, p, c, i % 4, 2, 1, 0);
      chk(kind == 2 && r_cause == 5'd1, "R7 access fault cause", r_cause, 1);
      chk(r_tval == a, "R7 trap value", r_tval, a);
      chk(r_epc == p, "R7 trap epc", r_epc, p);
    end

    // R1 classification over all top/low opcode bits
    for (int t = 0; t < 64; t++) begin
      for (int l = 0; l < 4; l++) begin
        logic [15:0] w;
        bit tj;
        w = {6'(t), 8'(t * 5 + l * 77), 2'(l)};
        tj = (t == 6'b101000) && (l == 2);
        run(w, 32'h100, 32'h0000_0400, 0, 1, 0, 0);
        if (tj) begin
          check_good(w, 32'h100, 32'h0000_0400);
        end else begin
          chk(kind == 3, "R1 reject pulse", kind, 3);
          chk(req_count == 0 && !busy, "R1 no request", req_count, 0);
        end
      end
    end

    // R8 start while busy is ignored
    for (int i = 0; i < 8; i++) begin
      logic [15:0] w;
      w = {6'b101000, 8'(i * 31), 2'b10};
      run(w, 32'h5000, 32'h0000_0080, 5, 3, 0, 1);
      chk(!saw_nm, "R8 no reject while busy", saw_nm, 0);
      check_good(w, 32'h5000, 32'h0000_0080);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule